// File: doc/BRIEF.md
# Configuration Access Trap Controller

This block observes configuration-space requests arriving on a simple request interface. Each request carries a function number, a register offset, a direction flag and write data. Four downstream functions (numbers 2 to 5) each have a trap-enable bit. When a valid request targets an enabled function, the block flags a trap.

On a trap, a write is held back from the function, while a read is allowed to complete and is only observed. The trap sets a summary status bit and a source status bit. While either bit is set, a system-management interrupt (SMI) output is held high. A capture register records the first trapped access, and software clears both status bits by writing ones to them. The block also holds a second control byte. That byte gates the forwarding of parity errors as system errors, the claiming of interrupt-acknowledge cycles, and the forwarding of subtractively decoded cycles to the external bus.

Software reaches all registers through a small select/write/read port. Reads on that port are combinational.

Top module: `cfg_trap_ctrl`

## Requirements
- R1: The trap-enable register (select 0, data bits 7:0) resets to 00h. Bits 5:2 are writable, and bit n enables trapping of function n. Bits 7:6 and 1:0 always read 0.
- R2: The bridge control register (select 1) resets to 39h. Bits 0, 1, 4 and 5 are writable. Bit 3 always reads 1, and bits 2, 6 and 7 always read 0.
- R3: `trap_hit` is high in the same cycle as a valid request whose function number is in 2..5 and whose trap-enable bit is set. Otherwise it is low.
- R4: A trapped write drives `fwd_ok` low in the same cycle. A valid write that is not trapped drives `fwd_ok` high.
- R5: A valid read drives `fwd_ok` high, whether or not it is trapped. With no valid request, `fwd_ok` is low.
- R6: Requests to function numbers 0, 1, 6 and 7, or to a function whose trap bit is clear, change no status and raise no SMI.
- R7: A trap sets bit 9 of the summary status word (select 2) and bit 5 of the source status word (select 3) at the next clock edge. Writing 1 to either bit clears that bit. If a trap and a clear land in the same cycle, the trap wins.
- R8: `smi` goes high one cycle after either status bit is set. It goes low one cycle after both bits are clear.
- R9: The capture word (select 4) holds the function in bits 2:0, the write flag in bit 3 and the offset in bits 15:8. All other bits read 0. It loads only on a trap while both status bits are clear, and it resets to 0. Unused select values read 0.
- R10: `serr_out` equals `perr_in` AND control bit 1. `inta_claim` equals `inta_cycle` AND control bit 0. `subdec_fwd` equals `subdec_in` AND control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Configuration request present |
| req_func | input | 3 | Target function number |
| req_offset | input | 8 | Target register offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data carried with the request (passed downstream, not inspected) |
| reg_sel | input | 3 | Register select for the control port |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational register read data |
| perr_in | input | 1 | Parity error seen |
| inta_cycle | input | 1 | Interrupt-acknowledge cycle seen |
| subdec_in | input | 1 | Subtractively decoded cycle seen |
| fwd_ok | output | 1 | Request may reach the downstream function |
| trap_hit | output | 1 | Current request is trapped |
| smi | output | 1 | System-management interrupt |
| serr_out | output | 1 | System error output |
| inta_claim | output | 1 | Claim the interrupt-acknowledge cycle |
| subdec_fwd | output | 1 | Forward subtractive cycle to external bus |

## Verification
The outputs `trap_hit`, `fwd_ok`, the three gated error and cycle outputs, and `reg_rdata` are due in the same cycle as their inputs, so they are sampled 1 ns after the falling edge on which the stimulus was driven. The status bits, the capture word and the control registers change one edge after the stimulus. The bench folds that change into its model right after the comparison, so the new value is checked in the next cycle. `smi` is due two edges after a trap and one edge after the last clear. The model keeps it as a register of its own status state, which gives it the same one-step lag. Constrained random requests, register writes and clear patterns run alongside directed cases: the reset values, mask writes, a single enabled function, a trap and a clear in the same cycle, and a capture being held.

// File: rtl/cfg_trap_pkg.sv
package cfg_trap_pkg;
  localparam int SEL_W       = 3;
  localparam logic [SEL_W-1:0] SEL_TRAP_EN = 3'd0;
  localparam logic [SEL_W-1:0] SEL_BRIDGE  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_SUMMARY = 3'd2;
  localparam logic [SEL_W-1:0] SEL_SOURCE  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CAPTURE = 3'd4;

  localparam int SUMMARY_BIT = 9;
  localparam int SOURCE_BIT  = 5;

  localparam int FIRST_FUNC = 2;
  localparam int LAST_FUNC  = 5;

  localparam logic [7:0] TRAP_WMASK   = 8'h3C;
  localparam logic [7:0] BRIDGE_WMASK = 8'h33;
  localparam logic [7:0] BRIDGE_FIXED = 8'h08;
  localparam logic [7:0] BRIDGE_RESET = 8'h39;

  localparam int CTL_INTA  = 0;
  localparam int CTL_SERR  = 1;
  localparam int CTL_SUBDC = 4;

  function automatic logic func_trapped(input logic [2:0] fn, input logic [7:0] en);
    return (int'(fn) >= FIRST_FUNC) && (int'(fn) <= LAST_FUNC) && en[fn];
  endfunction

  function automatic logic [15:0] pack_capture(input logic [7:0] ofs, input logic wr,
                                               input logic [2:0] fn);
    return {ofs, 4'b0000, wr, fn};
  endfunction
endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import cfg_trap_pkg::*;
(
  input  logic       req_valid,
  input  logic [2:0] req_func,
  input  logic       req_write,
  input  logic [7:0] trap_en,
  output logic       trap_hit,
  output logic       fwd_ok
);
  always_comb begin
    trap_hit = req_valid && func_trapped(req_func, trap_en);
    fwd_ok   = req_valid && !(trap_hit && req_write);
  end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import cfg_trap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [7:0]       wbyte,
  output logic [7:0]       trap_en,
  output logic [7:0]       bridge_ctl
);
  logic [7:0] trap_q;
  logic [7:0] bridge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q   <= 8'h00;
      bridge_q <= BRIDGE_RESET & BRIDGE_WMASK;
    end else if (reg_wr) begin
      if (reg_sel == SEL_TRAP_EN) trap_q   <= wbyte & TRAP_WMASK;
      if (reg_sel == SEL_BRIDGE)  bridge_q <= wbyte & BRIDGE_WMASK;
    end
  end

  assign trap_en    = trap_q;
  assign bridge_ctl = bridge_q | BRIDGE_FIXED;
endmodule

// File: rtl/trap_status.sv
module trap_status
  import cfg_trap_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_hit,
  input  logic [2:0]       req_func,
  input  logic [OFS_W-1:0] req_offset,
  input  logic             req_write,
  input  logic             clr_summary,
  input  logic             clr_source,
  output logic             summary_flag,
  output logic             source_flag,
  output logic             pending,
  output logic             smi,
  output logic [15:0]      capture
);
  logic        sum_q, src_q, smi_q;
  logic [15:0] cap_q;

  assign pending = sum_q | src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= 1'b0;
      src_q <= 1'b0;
      smi_q <= 1'b0;
      cap_q <= '0;
    end else begin
      sum_q <= trap_hit | (sum_q & ~clr_summary);
      src_q <= trap_hit | (src_q & ~clr_source);
      smi_q <= pending;
      if (trap_hit && !pending)
        cap_q <= pack_capture(req_offset[7:0], req_write, req_func);
    end
  end

  assign summary_flag = sum_q;
  assign source_flag  = src_q;
  assign smi          = smi_q;
  assign capture      = cap_q;
endmodule

// File: rtl/cfg_trap_ctrl.sv
module cfg_trap_ctrl
  import cfg_trap_pkg::*;
#(
  parameter int OFS_W  = 8,
  parameter int DATA_W = 16,
  parameter int REQ_DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_func,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic              req_write,
  input  logic [REQ_DW-1:0] req_wdata,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              perr_in,
  input  logic              inta_cycle,
  input  logic              subdec_in,
  output logic              fwd_ok,
  output logic              trap_hit,
  output logic              smi,
  output logic              serr_out,
  output logic              inta_claim,
  output logic              subdec_fwd
);
  logic [7:0]  trap_en;
  logic [7:0]  bridge_ctl;
  logic        summary_flag, source_flag, pending;
  logic [15:0] capture;
  logic        clr_summary, clr_source;
  logic        unused_bits;

  assign unused_bits = ^{req_wdata, reg_wdata[DATA_W-1:8]};

  assign clr_summary = reg_wr && (reg_sel == SEL_SUMMARY) && reg_wdata[SUMMARY_BIT];
  assign clr_source  = reg_wr && (reg_sel == SEL_SOURCE)  && reg_wdata[SOURCE_BIT];

  trap_decode u_dec (
    .req_valid (req_valid),
    .req_func  (req_func),
    .req_write (req_write),
    .trap_en   (trap_en),
    .trap_hit  (trap_hit),
    .fwd_ok    (fwd_ok)
  );

  trap_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .wbyte      (reg_wdata[7:0]),
    .trap_en    (trap_en),
    .bridge_ctl (bridge_ctl)
  );

  trap_status #(.OFS_W(OFS_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .trap_hit     (trap_hit),
    .req_func     (req_func),
    .req_offset   (req_offset),
    .req_write    (req_write),
    .clr_summary  (clr_summary),
    .clr_source   (clr_source),
    .summary_flag (summary_flag),
    .source_flag  (source_flag),
    .pending      (pending),
    .smi          (smi),
    .capture      (capture)
  );

  assign serr_out   = perr_in    & bridge_ctl[CTL_SERR];
  assign inta_claim = inta_cycle & bridge_ctl[CTL_INTA];
  assign subdec_fwd = subdec_in  & bridge_ctl[CTL_SUBDC];

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_TRAP_EN: reg_rdata[7:0] = trap_en;
      SEL_BRIDGE:  reg_rdata[7:0] = bridge_ctl;
      SEL_SUMMARY: reg_rdata[SUMMARY_BIT] = summary_flag;
      SEL_SOURCE:  reg_rdata[SOURCE_BIT]  = source_flag;
      SEL_CAPTURE: reg_rdata[15:0] = capture;
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_trap_chk.sv
module cfg_trap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  req_func,
  input logic        req_write,
  input logic        trap_hit,
  input logic        fwd_ok,
  input logic        summary_flag,
  input logic        source_flag,
  input logic        smi,
  input logic [15:0] capture,
  input logic [7:0]  trap_en,
  input logic        perr_in,
  input logic        serr_out
);
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_hit && req_write) |-> !fwd_ok); // R4
  AST_READ_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> fwd_ok); // R5
  AST_OUT_OF_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_func < 3'd2 || req_func > 3'd5) |-> !trap_hit); // R6
  AST_TRAP_EN_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_en[7:6] == 2'b00) && (trap_en[1:0] == 2'b00)); // R1
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> (summary_flag && source_flag)); // R7
  AST_SMI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (summary_flag || source_flag) |=> smi); // R8
  AST_SMI_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(summary_flag || source_flag) |=> !smi); // R8
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (summary_flag || source_flag) |=> $stable(capture)); // R9
  AST_SERR_NEEDS_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    serr_out |-> perr_in); // R10
endmodule

bind cfg_trap_ctrl cfg_trap_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_func     (req_func),
  .req_write    (req_write),
  .trap_hit     (trap_hit),
  .fwd_ok       (fwd_ok),
  .summary_flag (summary_flag),
  .source_flag  (source_flag),
  .smi          (smi),
  .capture      (capture),
  .trap_en      (trap_en),
  .perr_in      (perr_in),
  .serr_out     (serr_out)
);

// File: tb/cfg_trap_ctrl_test.sv
`timescale 1ns/1ps
module cfg_trap_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_offset = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic [2:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        perr_in = 1'b0, inta_cycle = 1'b0, subdec_in = 1'b0;
  logic        fwd_ok, trap_hit, smi, serr_out, inta_claim, subdec_fwd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_trap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_func(req_func),
    .req_offset(req_offset), .req_write(req_write), .req_wdata(req_wdata),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .perr_in(perr_in), .inta_cycle(inta_cycle), .subdec_in(subdec_in),
    .fwd_ok(fwd_ok), .trap_hit(trap_hit), .smi(smi), .serr_out(serr_out),
    .inta_claim(inta_claim), .subdec_fwd(subdec_fwd)
  );

  // bench model state
  logic [7:0]  m_en, m_ctl;
  logic        m_sum, m_src, m_smi;
  logic [15:0] m_cap;

  function automatic logic exp_trap(input logic v, input logic [2:0] f, input logic [7:0] en);
    if (!v) return 1'b0;
    case (f)
      3'd2, 3'd3, 3'd4, 3'd5: return en[f];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] exp_read(input logic [2:0] s);
    case (s)
      3'd0: return {8'h00, m_en};
      3'd1: return {8'h00, m_ctl};
      3'd2: return 16'(m_sum) << 9;
      3'd3: return 16'(m_src) << 5;
      3'd4: return m_cap;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string read_tag(input logic [2:0] s);
    case (s)
      3'd0: return "R1 trap enable read";
      3'd1: return "R2 bridge control read";
      3'd2, 3'd3: return "R7 status read";
      default: return "R9 capture/unused read";
    endcase
  endfunction

  task automatic step(input logic v, input logic [2:0] f, input logic [7:0] o, input logic w,
                      input logic rw, input logic [2:0] rs, input logic [15:0] rd,
                      input logic pe, input logic ia, input logic sd);
    logic t;
    @(negedge clk);
    req_valid = v; req_func = f; req_offset = o; req_write = w; req_wdata = o ^ 8'h5A;
    reg_wr = rw; reg_sel = rs; reg_wdata = rd;
    perr_in = pe; inta_cycle = ia; subdec_in = sd;
    #1;
    t = exp_trap(v, f, m_en);
    check("R3 trap_hit", 16'(trap_hit), 16'(t));
    check(w ? "R4 fwd_ok write" : "R5 fwd_ok read", 16'(fwd_ok), 16'(v && !(t && w)));
    check("R8 smi", 16'(smi), 16'(m_smi));
    check("R10 serr_out", 16'(serr_out), 16'(pe & m_ctl[1]));
    check("R10 inta_claim", 16'(inta_claim), 16'(ia & m_ctl[0]));
    check("R10 subdec_fwd", 16'(subdec_fwd), 16'(sd & m_ctl[4]));
    check(read_tag(rs), reg_rdata, exp_read(rs));
    // advance the model to the state after the coming edge
    m_smi = m_sum | m_src;
    if (t && !(m_sum | m_src)) m_cap = {o, 4'b0000, w, f};
    m_sum = t | (m_sum & ~(rw && rs == 3'd2 && rd[9]));
    m_src = t | (m_src & ~(rw && rs == 3'd3 && rd[5]));
    if (rw && rs == 3'd0) m_en  = rd[7:0] & 8'h3C;
    if (rw && rs == 3'd1) m_ctl = (rd[7:0] & 8'h33) | 8'h08;
  endtask

  task automatic reset_model();
    m_en = 8'h00; m_ctl = 8'h39; m_sum = 1'b0; m_src = 1'b0; m_smi = 1'b0; m_cap = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    reset_model();
    repeat (3) @(posedge clk);
    // reset values while reset is held (R1, R2)
    @(negedge clk); reg_sel = 3'd0; #1; check("R1 reset trap enable", reg_rdata, 16'h0000);
    @(negedge clk); reg_sel = 3'd1; #1; check("R2 reset bridge control", reg_rdata, 16'h0039);
    @(negedge clk); reg_sel = 3'd4; #1; check("R9 reset capture", reg_rdata, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // R1 mask: write all ones, expect 3Ch
    step(0, 0, 0, 0, 1, 3'd0, 16'hFFFF, 0, 0, 0);
    step(0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 0);
    // R2 mask: write zeros, bit 3 stays
    step(0, 0, 0, 0, 1, 3'd1, 16'h0000, 0, 0, 0);
    step(0, 0, 0, 0, 0, 3'd1, 0, 1, 1, 1);
    step(0, 0, 0, 0, 1, 3'd1, 16'hFFFF, 0, 0, 0);
    step(0, 0, 0, 0, 0, 3'd1, 0, 1, 1, 1);
    // R6: only function 2 enabled, accesses elsewhere stay quiet
    step(0, 0, 0, 0, 1, 3'd0, 16'h0004, 0, 0, 0);
    step(1, 3'd3, 8'h10, 1, 0, 3'd2, 0, 0, 0, 0);
    step(1, 3'd7, 8'h10, 1, 0, 3'd3, 0, 0, 0, 0);
    step(1, 3'd1, 8'h10, 0, 0, 3'd2, 0, 0, 0, 0);
    // R4/R7/R9: trapped write, then a second trap must not move the capture
    step(1, 3'd2, 8'hA4, 1, 0, 3'd2, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 3'd2, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3'd0, 16'h003C, 0, 0, 0);
    step(1, 3'd5, 8'h33, 0, 0, 3'd4, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 3'd4, 0, 0, 0, 0);
    // R7: clear while a trap lands, trap wins; then clear both, R8 smi falls
    step(1, 3'd4, 8'h08, 0, 1, 3'd2, 16'h0200, 0, 0, 0);
    step(0, 0, 0, 0, 0, 3'd2, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3'd2, 16'h0200, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3'd3, 16'h0020, 0, 0, 0);
    step(0, 0, 0, 0, 0, 3'd3, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 3'd4, 0, 0, 0, 0);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      logic [2:0] rs;
      logic [15:0] rd;
      r  = $urandom;
      rs = 3'($urandom_range(0, 5));
      rd = 16'($urandom);
      if (rs == 3'd2) rd[9] = r[20];
      if (rs == 3'd3) rd[5] = r[21];
      step(r[0] | r[1], r[4:2], r[12:5], r[13], (r[17:14] == 4'd0), rs, rd,
           r[22], r[23], r[24]);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule